// File: doc/BRIEF.md
# Dual-Mode Interrupt Down-Counter

This block is the interrupt timer of a cartridge address mapper. A signed down-counter is reloaded from an 8-bit latch. It counts down either once per visible display line while rendering is on, or once per four CPU cycles. When a decrement takes the counter from zero to minus one and interrupts are enabled, the block raises a level interrupt request. That request stays high until software acknowledges it.

Software reaches the block through four write targets, chosen by a 2-bit select:

| Code | Target |
|------|--------|
| 0 | Latch |
| 1 | Reload and mode |
| 2 | Disable and acknowledge |
| 3 | Enable |

A reload flag is set by the mode write. While that flag is set, writes to the latch, disable and enable targets also reload the counter. In line mode every line event clears the flag. An underflow in line mode that raises the request sets the flag again.

Top module: `irq_line_timer`

## Requirements
- R1: Reset clears the latch, the counter, the prescaler, the enable and the reload flag, selects line mode, and drives `irq` low.
- R2: A write with select 0 stores `wr_data` in the latch. When the reload flag is set, the same write also loads the counter with `wr_data`.
- R3: A write with select 1 sets the reload flag and loads the counter from the latch. It also sets the mode from `wr_data[0]`: 0 selects line mode and 1 selects cycle mode.
- R4: A write with select 2 clears the enable and drives `irq` low at the next edge. When the reload flag is set, it also reloads the counter from the latch.
- R5: A write with select 3 sets the enable. When the reload flag is set, it also reloads the counter from the latch.
- R6: In cycle mode, every fourth `cpu_tick` since reset produces one decrement.
- R7: A decrement happens only while the counter is zero or positive. The step from 0 to -1 raises `irq`, but only if the enable is set. A negative counter holds its value until it is reloaded.
- R8: In line mode, each `line_tick` clears the reload flag. It decrements the counter only when `line_num` is 239 or less and `render_on` is high.
- R9: In line mode, an underflow that raises `irq` leaves the reload flag set.
- R10: Line events have no effect in cycle mode. CPU ticks have no effect in line mode.
- R11: Once `irq` is high, it falls only on a select-2 write or on reset.
- R12: In a cycle that carries a register write, the write is applied and any line event or prescaler step in that same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_reg | input | 2 | Write target select: 0 latch, 1 reload/mode, 2 disable, 3 enable |
| wr_data | input | 8 | Write data |
| cpu_tick | input | 1 | One pulse per CPU cycle |
| line_tick | input | 1 | One pulse per display line |
| line_num | input | 9 | Line number carried with `line_tick` |
| render_on | input | 1 | Rendering enabled |
| irq | output | 1 | Active-high interrupt request |

## Verification
Every write and every tick acts on the clock edge where it is presented. The registered `irq` therefore shows its result right after that same edge, with no further delay. In cycle mode, `irq` rises on the edge of the fourth tick that completes the underflowing period. The bench drives each input on a falling edge and holds it across exactly one rising edge. It then reads `irq` on the next falling edge, so every check sits one half-period after the edge that is due to change `irq`. Counter values are inferred by counting ticks up to the edge where `irq` rises. The checks are placed one tick before and exactly at that edge.

// File: rtl/irqt_pkg.sv
package irqt_pkg;
   typedef enum logic [1:0] {
      SEL_LATCH = 2'd0,
      SEL_MODE  = 2'd1,
      SEL_OFF   = 2'd2,
      SEL_ON    = 2'd3
   } irqt_sel_e;

   typedef enum logic {
      MODE_LINE  = 1'b0,
      MODE_CYCLE = 1'b1
   } irqt_mode_e;
endpackage

// File: rtl/irqt_prescaler.sv
module irqt_prescaler #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   output logic step
);
   localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   logic [PW-1:0] pre_q;

   generate
      if ((DIV & (DIV - 1)) == 0) begin : g_pow2
         // counter wraps naturally at the power-of-two boundary
         assign step = run & tick & (&pre_q);
         always_ff @(posedge clk) begin
            if (!rst_n)
               pre_q <= '0;
            else if (run && tick)
               pre_q <= pre_q + 1'b1;
         end
      end else begin : g_cmp
         assign step = run & tick & (pre_q == LAST);
         always_ff @(posedge clk) begin
            if (!rst_n)
               pre_q <= '0;
            else if (run && tick)
               pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/irqt_down_counter.sv
module irqt_down_counter #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt_q,
   output logic             underflow
);
   logic neg;

   assign neg       = cnt_q[CNT_W-1];
   assign underflow = dec & ~neg & (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (dec && !neg)
         cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/irqt_ctrl.sv
module irqt_ctrl
   import irqt_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int CNT_W     = DATA_W + 1,
   parameter int LINE_W    = 9,
   parameter int LAST_LINE = 239
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_reg,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              line_tick,
   input  logic [LINE_W-1:0] line_num,
   input  logic              render_on,
   input  logic              step,
   input  logic              underflow,
   output logic              load,
   output logic [CNT_W-1:0]  load_val,
   output logic              dec,
   output logic [DATA_W-1:0] latch_q,
   output logic              mode_q,
   output logic              en_q,
   output logic              irq_q
);
   localparam int PAD = CNT_W - DATA_W;

   irqt_sel_e sel;
   logic      reload_q;
   logic      line_ev;
   logic      line_ok;
   logic      cyc_ev;

   assign sel     = irqt_sel_e'(wr_reg);
   assign line_ev = line_tick & (mode_q == MODE_LINE) & ~wr_en;
   assign line_ok = line_ev & render_on & (line_num <= LINE_W'(LAST_LINE));
   assign cyc_ev  = step & (mode_q == MODE_CYCLE) & ~wr_en;
   assign dec     = line_ok | cyc_ev;

   always_comb begin
      load     = 1'b0;
      load_val = {{PAD{1'b0}}, latch_q};
      if (wr_en) begin
         unique case (sel)
            SEL_LATCH: begin
               load     = reload_q;
               load_val = {{PAD{1'b0}}, wr_data};
            end
            SEL_MODE: load = 1'b1;
            default:  load = reload_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch_q  <= '0;
         mode_q   <= MODE_LINE;
         en_q     <= 1'b0;
         reload_q <= 1'b0;
         irq_q    <= 1'b0;
      end else if (wr_en) begin
         unique case (sel)
            SEL_LATCH: latch_q <= wr_data;
            SEL_MODE: begin
               reload_q <= 1'b1;
               mode_q   <= wr_data[0];
            end
            SEL_OFF: begin
               en_q  <= 1'b0;
               irq_q <= 1'b0;
            end
            SEL_ON: en_q <= 1'b1;
         endcase
      end else if (line_ev) begin
         reload_q <= underflow & en_q;
         if (underflow && en_q)
            irq_q <= 1'b1;
      end else if (cyc_ev) begin
         if (underflow && en_q)
            irq_q <= 1'b1;
      end
   end
endmodule

// File: rtl/irq_line_timer.sv
module irq_line_timer #(
   parameter int DATA_W    = 8,
   parameter int LINE_W    = 9,
   parameter int LAST_LINE = 239,
   parameter int PRE_DIV   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_reg,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              cpu_tick,
   input  logic              line_tick,
   input  logic [LINE_W-1:0] line_num,
   input  logic              render_on,
   output logic              irq
);
   localparam int CNT_W = DATA_W + 1;

   generate
      if (PRE_DIV < 2) begin : g_bad_div
         $error("PRE_DIV must be at least 2");
      end
      if (LAST_LINE >= (1 << LINE_W)) begin : g_bad_line
         $error("LAST_LINE does not fit in LINE_W bits");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
   endgenerate

   logic              step;
   logic              load;
   logic [CNT_W-1:0]  load_val;
   logic              dec;
   logic              underflow;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] latch_q;
   logic              mode_q;
   logic              en_q;
   logic              irq_q;

   irqt_prescaler #(.DIV(PRE_DIV)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (mode_q),
      .tick (cpu_tick),
      .step (step)
   );

   irqt_ctrl #(
      .DATA_W   (DATA_W),
      .CNT_W    (CNT_W),
      .LINE_W   (LINE_W),
      .LAST_LINE(LAST_LINE)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_reg   (wr_reg),
      .wr_data  (wr_data),
      .line_tick(line_tick),
      .line_num (line_num),
      .render_on(render_on),
      .step     (step),
      .underflow(underflow),
      .load     (load),
      .load_val (load_val),
      .dec      (dec),
      .latch_q  (latch_q),
      .mode_q   (mode_q),
      .en_q     (en_q),
      .irq_q    (irq_q)
   );

   irqt_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .dec      (dec),
      .cnt_q    (cnt_q),
      .underflow(underflow)
   );

   assign irq = irq_q;
endmodule

// File: rtl/irqt_checker.sv
module irqt_checker #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_reg,
   input logic              cpu_tick,
   input logic              line_tick,
   input logic              irq,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [DATA_W-1:0] latch_q,
   input logic              mode_q,
   input logic              en_q
);
   p_off_clears_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_reg == 2'd2) |=> !irq);

   p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(en_q));

   p_negative_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[CNT_W-1] && !wr_en) |=> $stable(cnt_q));

   p_mode_write_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_reg == 2'd1) |=> (cnt_q == {{(CNT_W-DATA_W){1'b0}}, $past(latch_q)}));

   p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(wr_en && wr_reg == 2'd2));

   p_line_ignored_in_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && mode_q && line_tick && !cpu_tick) |=> $stable(cnt_q));

   p_cpu_ignored_in_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !mode_q && cpu_tick && !line_tick) |=> $stable(cnt_q));
endmodule

bind irq_line_timer irqt_checker #(
   .DATA_W(DATA_W),
   .CNT_W (CNT_W)
) u_irqt_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_reg   (wr_reg),
   .cpu_tick (cpu_tick),
   .line_tick(line_tick),
   .irq      (irq),
   .cnt_q    (cnt_q),
   .latch_q  (latch_q),
   .mode_q   (mode_q),
   .en_q     (en_q)
);

// File: tb/test_irq_line_timer.sv
`timescale 1ns/1ps
module test_irq_line_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_reg = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic       cpu_tick = 1'b0;
   logic       line_tick = 1'b0;
   logic [8:0] line_num = 9'd0;
   logic       render_on = 1'b0;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_line_timer i_irq_line_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_reg   (wr_reg),
      .wr_data  (wr_data),
      .cpu_tick (cpu_tick),
      .line_tick(line_tick),
      .line_num (line_num),
      .render_on(render_on),
      .irq      (irq)
   );

   task automatic chk(string req, logic act, logic exp, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: irq=%0b expected %0b", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(logic [1:0] sel, logic [7:0] data);
      wr_en = 1'b1; wr_reg = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic lines(logic [8:0] num, logic ren, int n);
      for (int i = 0; i < n; i++) begin
         line_tick = 1'b1; line_num = num; render_on = ren;
         @(negedge clk);
         line_tick = 1'b0;
      end
   endtask

   task automatic cpus(int n);
      for (int i = 0; i < n; i++) begin
         cpu_tick = 1'b1;
         @(negedge clk);
         cpu_tick = 1'b0;
      end
   endtask

   task automatic t_reset_state();
      do_reset();
      chk("R1", irq, 1'b0, "irq after reset");
      wr(2'd3, 8'd0);            // enable, flag clear: counter stays 0
      chk("R1", irq, 1'b0, "idle after enable");
      lines(9'd10, 1'b1, 1);     // 0 -> -1 in line mode
      chk("R1", irq, 1'b1, "counter cleared and line mode after reset");
      repeat (3) @(negedge clk);
      wr(2'd0, 8'd9);
      chk("R11", irq, 1'b1, "irq held across idle and latch write");
      wr(2'd2, 8'd0);
      chk("R4", irq, 1'b0, "disable write clears irq");
   endtask

   task automatic t_line_count();
      do_reset();
      wr(2'd0, 8'd3);
      wr(2'd1, 8'd0);            // flag set, counter 3, line mode
      wr(2'd3, 8'd0);            // reload 3
      cpus(20);
      chk("R10", irq, 1'b0, "cpu ticks ignored in line mode");
      lines(9'd20, 1'b1, 3);
      chk("R3", irq, 1'b0, "three lines from 3");
      lines(9'd21, 1'b1, 1);
      chk("R8", irq, 1'b1, "fourth line underflows");
   endtask

   task automatic t_line_filter();
      do_reset();
      wr(2'd0, 8'd1);
      wr(2'd1, 8'd0);
      wr(2'd3, 8'd0);
      lines(9'd240, 1'b1, 1);
      lines(9'd5, 1'b0, 1);
      lines(9'd239, 1'b1, 1);
      chk("R8", irq, 1'b0, "line 240 and render off do not count");
      lines(9'd0, 1'b1, 1);
      chk("R8", irq, 1'b1, "line 0 counts");
   endtask

   task automatic t_flag_clear();
      do_reset();
      wr(2'd0, 8'd5);
      wr(2'd1, 8'd0);            // counter 5, flag set
      lines(9'd300, 1'b1, 1);    // clears flag, no decrement
      wr(2'd0, 8'd0);            // flag clear: no load
      wr(2'd3, 8'd0);
      lines(9'd1, 1'b1, 1);
      chk("R8", irq, 1'b0, "line event cleared reload flag");
      lines(9'd2, 1'b1, 4);
      chk("R2", irq, 1'b0, "latch write without flag left counter");
      lines(9'd3, 1'b1, 1);
      chk("R8", irq, 1'b1, "sixth line underflows from 5");
   endtask

   task automatic t_line_sets_flag();
      do_reset();
      wr(2'd0, 8'd0);
      wr(2'd1, 8'd0);
      wr(2'd3, 8'd0);
      lines(9'd1, 1'b1, 1);
      chk("R9", irq, 1'b1, "underflow from 0");
      wr(2'd0, 8'd2);            // flag set by underflow: counter 2
      wr(2'd2, 8'd0);            // reload 2, disable
      chk("R4", irq, 1'b0, "acknowledge");
      wr(2'd3, 8'd0);            // reload 2
      lines(9'd7, 1'b1, 2);
      chk("R5", irq, 1'b0, "two lines from 2");
      lines(9'd8, 1'b1, 1);
      chk("R9", irq, 1'b1, "reload via flag restored count");
   endtask

   task automatic t_cycle_mode();
      do_reset();
      wr(2'd0, 8'd2);
      wr(2'd1, 8'd1);            // cycle mode, counter 2
      wr(2'd3, 8'd0);
      lines(9'd10, 1'b1, 5);
      chk("R10", irq, 1'b0, "lines ignored in cycle mode");
      cpus(11);
      chk("R6", irq, 1'b0, "eleven cpu ticks");
      cpus(1);
      chk("R6", irq, 1'b1, "twelfth cpu tick underflows");
      cpus(9);
      wr(2'd3, 8'd0);
      chk("R11", irq, 1'b1, "irq held over ticks and enable write");
      wr(2'd2, 8'd0);
      chk("R11", irq, 1'b0, "only disable clears");
   endtask

   task automatic t_no_enable();
      do_reset();
      wr(2'd0, 8'd0);
      wr(2'd1, 8'd0);
      lines(9'd3, 1'b1, 1);      // 0 -> -1, flag cleared, disabled
      chk("R7", irq, 1'b0, "underflow while disabled");
      wr(2'd3, 8'd0);            // no reload
      lines(9'd4, 1'b1, 5);
      chk("R7", irq, 1'b0, "negative counter holds");
   endtask

   task automatic t_write_priority();
      do_reset();
      wr(2'd0, 8'd1);
      wr(2'd1, 8'd0);
      lines(9'd100, 1'b1, 1);    // flag clear, counter 0
      wr(2'd3, 8'd0);
      wr_en = 1'b1; wr_reg = 2'd0; wr_data = 8'd7;
      line_tick = 1'b1; line_num = 9'd10; render_on = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; line_tick = 1'b0;
      chk("R12", irq, 1'b0, "line event dropped under write");
      lines(9'd11, 1'b1, 1);
      chk("R12", irq, 1'b1, "next line underflows");
   endtask

   initial begin
      t_reset_state();
      t_line_count();
      t_line_filter();
      t_flag_clear();
      t_line_sets_flag();
      t_cycle_mode();
      t_no_enable();
      t_write_priority();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #500000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule